// File: doc/BRIEF.md
# Video Output Pixel FIFO

This block sits between a host processor's memory bus and a video output path. The host pushes 16-bit pixel words into a 256-word first-in first-out buffer. The video side pops them in order. A status word gives the host the free space, the empty and full flags, a threshold flag and a sticky error flag. It also reads back the current settings of the two control bits.

A programmable trigger level (1 to 255) sets the threshold flag whenever at least that many words can still be written. When enabled, this flag drives an interrupt request, so the host can refill the buffer in bursts. A control write can flush the buffer and set two bits. The first bit selects whether the host-side transfer stalls while the buffer is full or keeps running. In the second case, writes made while full are dropped and flagged. The second bit enables the interrupt.

Top module: `vout_fifo`

## Requirements
- R1: After reset, status reads free space 255, empty 1, full 0, threshold flag 1, error 0, continue mode 0 and interrupt enable 0. The trigger register reads 128 and `irq_o` is 0.
- R2: Status bits [7:0] hold the number of words that can still be written, saturated at 255. With 256 words free this field reads 255.
- R3: Status bit 8 is empty and is 1 exactly when no word is stored. Status bit 9 is full and is 1 exactly when 256 words are stored.
- R4: Status bit 10, the threshold flag, is 1 exactly when the unsaturated free space is at least the trigger value.
- R5: A trigger write with a value from 1 to 255 loads that value, and `trig_o` shows it from the next cycle. A trigger write of 0 is ignored.
- R6: A push while full is discarded. The stored words and their order are unchanged, and a later drain returns every accepted word in push order.
- R7: A push while full sets the error flag, status bit 11. The flag stays set until a clear or a reset.
- R8: A control write with bit 0 set empties the buffer and clears the error flag in one cycle. It leaves the trigger register unchanged. A push or pop in the same cycle is dropped.
- R9: Control bit 1, read back in status bit 12, selects continue mode. When it is 0, `wr_ready_o` is 0 while full and 1 otherwise. When it is 1, `wr_ready_o` is always 1.
- R10: Control bit 2, read back in status bit 13, enables the interrupt. `irq_o` is 1 exactly when this bit and the threshold flag are both 1.
- R11: `rd_valid_o` equals not-empty and `rd_data_o` shows the oldest word. `rd_en_i` removes that word, and a pop while empty has no effect. A push and a pop in the same cycle on a partly filled buffer leave the free space unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host pushes `wr_data_i` this cycle |
| wr_data_i | input | 16 | Pixel word from host |
| wr_ready_o | output | 1 | Host-side transfer may proceed |
| rd_en_i | input | 1 | Video side pops the oldest word |
| rd_data_o | output | 16 | Oldest stored word |
| rd_valid_o | output | 1 | A word is available |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 3 | Bit 0 clear, bit 1 continue mode, bit 2 interrupt enable |
| trig_we_i | input | 1 | Trigger write strobe |
| trig_wdata_i | input | 8 | New trigger level |
| status_o | output | 32 | Status word (fields per R2 to R10, other bits 0) |
| trig_o | output | 8 | Current trigger level |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks the buffer through every fill level from empty to full under several trigger levels, including 1, 128, 254 and 255. This catches a free-space field that wraps to 0 at 256 free words instead of saturating, and a threshold compare that is off by one at equality. It then pushes into a full buffer in both modes and drains all 256 words against the pattern. A design that overwrites the oldest word or advances its write pointer on a rejected push shows up as a data miscompare. The same step also checks that the error flag is set and stays set. Clear is exercised after a trigger change, which exposes a design that resets the trigger or leaves stale pointers or a stale error behind.

// File: rtl/vout_fifo_pkg.sv
package vout_fifo_pkg;
  // status word bit positions
  localparam int ST_EMPTY = 8;
  localparam int ST_FULL  = 9;
  localparam int ST_TRIG  = 10;
  localparam int ST_ERR   = 11;
  localparam int ST_CONT  = 12;
  localparam int ST_IRQEN = 13;
  // control write bit positions
  localparam int CT_CLR   = 0;
  localparam int CT_CONT  = 1;
  localparam int CT_IRQEN = 2;
  localparam int CT_W     = 3;
  localparam int ST_W     = 32;
endpackage

// File: rtl/vfifo_store.sv
module vfifo_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/vfifo_occ.sv
module vfifo_occ #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + AW'(1);
      if (pop_i)  rptr_q <= rptr_q + AW'(1);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign count_o = count_q;
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
endmodule

// File: rtl/vfifo_cfg.sv
module vfifo_cfg #(
  parameter int LVL_W    = 8,
  parameter int TRIG_RST = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             clr_i,
  input  logic             cont_i,
  input  logic             irqen_i,
  input  logic             trig_we_i,
  input  logic [LVL_W-1:0] trig_wdata_i,
  input  logic             wr_full_i,
  output logic             cont_o,
  output logic             irqen_o,
  output logic [LVL_W-1:0] trig_o,
  output logic             err_o
);
  logic             cont_q, irqen_q, err_q;
  logic [LVL_W-1:0] trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_q  <= 1'b0;
      irqen_q <= 1'b0;
      trig_q  <= LVL_W'(TRIG_RST);
      err_q   <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        cont_q  <= cont_i;
        irqen_q <= irqen_i;
      end
      // zero is not a legal level: keep previous value
      if (trig_we_i && (trig_wdata_i != '0)) trig_q <= trig_wdata_i;
      if (clr_i)          err_q <= 1'b0;
      else if (wr_full_i) err_q <= 1'b1;
    end
  end

  assign cont_o  = cont_q;
  assign irqen_o = irqen_q;
  assign trig_o  = trig_q;
  assign err_o   = err_q;
endmodule

// File: rtl/vout_fifo.sv
module vout_fifo
  import vout_fifo_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DEPTH    = 256,
  parameter int LVL_W    = 8,
  parameter int TRIG_RST = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             wr_ready_o,
  input  logic             rd_en_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  input  logic             ctrl_we_i,
  input  logic [CT_W-1:0]  ctrl_wdata_i,
  input  logic             trig_we_i,
  input  logic [LVL_W-1:0] trig_wdata_i,
  output logic [ST_W-1:0]  status_o,
  output logic [LVL_W-1:0] trig_o,
  output logic             irq_o
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = AW + 1;
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  logic          clr, push, pop, wr_full;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          empty, full;
  logic          cont, irqen, err, trig_flag;
  logic [31:0]   free_w;
  logic [LVL_W-1:0] free_lvl;

  assign clr     = ctrl_we_i & ctrl_wdata_i[CT_CLR];
  assign push    = wr_valid_i & ~full & ~clr;
  assign pop     = rd_en_i & ~empty & ~clr;
  assign wr_full = wr_valid_i & full & ~clr;

  vfifo_occ #(.DEPTH(DEPTH)) u_occ (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .flush_i (clr),
    .wptr_o  (wptr),
    .rptr_o  (rptr),
    .count_o (count),
    .empty_o (empty),
    .full_o  (full)
  );

  vfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wptr),
    .wdata_i (wr_data_i),
    .raddr_i (rptr),
    .rdata_o (rd_data_o)
  );

  vfifo_cfg #(.LVL_W(LVL_W), .TRIG_RST(TRIG_RST)) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .clr_i        (clr),
    .cont_i       (ctrl_wdata_i[CT_CONT]),
    .irqen_i      (ctrl_wdata_i[CT_IRQEN]),
    .trig_we_i    (trig_we_i),
    .trig_wdata_i (trig_wdata_i),
    .wr_full_i    (wr_full),
    .cont_o       (cont),
    .irqen_o      (irqen),
    .trig_o       (trig_o),
    .err_o        (err)
  );

  assign free_w    = 32'(DEPTH) - 32'(count);
  assign free_lvl  = (free_w > 32'(LVL_MAX)) ? LVL_W'(LVL_MAX) : free_w[LVL_W-1:0];
  assign trig_flag = (free_w >= 32'(trig_o));

  always_comb begin
    status_o            = '0;
    status_o[LVL_W-1:0] = free_lvl;
    status_o[ST_EMPTY]  = empty;
    status_o[ST_FULL]   = full;
    status_o[ST_TRIG]   = trig_flag;
    status_o[ST_ERR]    = err;
    status_o[ST_CONT]   = cont;
    status_o[ST_IRQEN]  = irqen;
  end

  assign wr_ready_o = cont | ~full;
  assign rd_valid_o = ~empty;
  assign irq_o      = irqen & trig_flag;
endmodule

// File: rtl/vout_fifo_chk.sv
module vout_fifo_chk
  import vout_fifo_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             rd_en_i,
  input logic             ctrl_we_i,
  input logic [CT_W-1:0]  ctrl_wdata_i,
  input logic             trig_we_i,
  input logic [LVL_W-1:0] trig_wdata_i,
  input logic [ST_W-1:0]  status_o,
  input logic [LVL_W-1:0] trig_o,
  input logic             wr_ready_o,
  input logic             irq_o
);
  logic clr;
  assign clr = ctrl_we_i & ctrl_wdata_i[CT_CLR];

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[ST_FULL] && status_o[ST_EMPTY])); // R3
  AST_TRIG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_TRIG] == (status_o[LVL_W-1:0] >= trig_o)); // R4
  AST_TRIG_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o != '0); // R5
  AST_TRIG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_we_i && (trig_wdata_i != '0) |=> trig_o == $past(trig_wdata_i)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_FULL] && wr_valid_i && !rd_en_i && !clr
    |=> status_o[ST_FULL] && (status_o[LVL_W-1:0] == '0)); // R6
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_FULL] && wr_valid_i && !clr |=> status_o[ST_ERR]); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_ERR] && !clr |=> status_o[ST_ERR]); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> status_o[ST_EMPTY] && !status_o[ST_ERR]); // R8
  AST_CLEAR_KEEP_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !trig_we_i |=> $stable(trig_o)); // R8
  AST_PAUSE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_FULL] && !status_o[ST_CONT] |-> !wr_ready_o); // R9
  AST_CONT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ST_CONT] |-> wr_ready_o); // R9
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o[ST_IRQEN] && status_o[ST_TRIG])); // R10
endmodule

bind vout_fifo vout_fifo_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .rd_en_i      (rd_en_i),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .trig_we_i    (trig_we_i),
  .trig_wdata_i (trig_wdata_i),
  .status_o     (status_o),
  .trig_o       (trig_o),
  .wr_ready_o   (wr_ready_o),
  .irq_o        (irq_o)
);

// File: tb/vout_fifo_tb_top.sv
module vout_fifo_tb_top;
  localparam int DEPTH = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        wr_ready_o;
  logic        rd_en_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rd_valid_o;
  logic        ctrl_we_i = 1'b0;
  logic [2:0]  ctrl_wdata_i = '0;
  logic        trig_we_i = 1'b0;
  logic [7:0]  trig_wdata_i = '0;
  logic [31:0] status_o;
  logic [7:0]  trig_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  vout_fifo dut_i (.*);

  function automatic logic [15:0] pat(int k);
    return 16'((k * 16'h1357) ^ 16'h5A3C);
  endfunction

  function automatic int exp_free(int lvl);
    return ((DEPTH - lvl) > 255) ? 255 : (DEPTH - lvl);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(logic [15:0] d);
    @(negedge clk_i); wr_valid_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_valid_i = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk_i); rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0;
  endtask

  task automatic ctrl(logic [2:0] v);
    @(negedge clk_i); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 1'b0;
  endtask

  task automatic set_trig(logic [7:0] v);
    @(negedge clk_i); trig_we_i = 1'b1; trig_wdata_i = v;
    @(negedge clk_i); trig_we_i = 1'b0;
  endtask

  // checks every status field against a fill level and settings
  task automatic chk_level(string req, int lvl, int trig, bit ien, bit cont);
    bit flag;
    flag = ((DEPTH - lvl) >= trig);
    chk({req, " R2 free"}, int'(status_o[7:0]), exp_free(lvl));
    chk({req, " R3 empty"}, int'(status_o[8]), int'(lvl == 0));
    chk({req, " R3 full"}, int'(status_o[9]), int'(lvl == DEPTH));
    chk({req, " R4 flag"}, int'(status_o[10]), int'(flag));
    chk({req, " R10 irq"}, int'(irq_o), int'(flag && ien));
    chk({req, " R9 ready"}, int'(wr_ready_o), int'(cont || lvl != DEPTH));
    chk({req, " R11 valid"}, int'(rd_valid_o), int'(lvl != 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int trigs[7] = '{1, 2, 17, 128, 200, 254, 255};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 free", int'(status_o[7:0]), 255);
    chk("R1 empty", int'(status_o[8]), 1);
    chk("R1 full", int'(status_o[9]), 0);
    chk("R1 flag", int'(status_o[10]), 1);
    chk("R1 err", int'(status_o[11]), 0);
    chk("R1 cont", int'(status_o[12]), 0);
    chk("R1 irqen", int'(status_o[13]), 0);
    chk("R1 trig", int'(trig_o), 128);
    chk("R1 irq", int'(irq_o), 0);

    // R11 pop on empty has no effect
    pop();
    chk_level("R11 pop-empty", 0, 128, 0, 0);

    // fill sweep, pause mode, trigger 128
    for (int k = 1; k <= DEPTH; k++) begin
      push(pat(k));
      chk_level("fill", k, 128, 0, 0);
    end
    chk("R7 err before overflow", int'(status_o[11]), 0);

    // R6/R7 push while full in pause mode
    push(16'hDEAD);
    chk_level("R6 overflow", DEPTH, 128, 0, 0);
    chk("R7 err set", int'(status_o[11]), 1);

    // R9 continue mode: ready while full, error stays
    ctrl(3'b010);
    chk("R9 cont bit", int'(status_o[12]), 1);
    chk_level("R9 cont full", DEPTH, 128, 0, 1);
    push(16'hBEEF);
    chk_level("R6 overflow cont", DEPTH, 128, 0, 1);
    chk("R7 err sticky ctrl", int'(status_o[11]), 1);

    // R6 drain: order and content intact
    for (int i = 1; i <= DEPTH; i++) begin
      chk("R6 data", int'(rd_data_o), int'(pat(i)));
      pop();
      chk_level("drain", DEPTH - i, 128, 0, 1);
      chk("R7 err sticky pop", int'(status_o[11]), 1);
    end

    // R8 clear keeps trigger, clears error
    set_trig(8'd37);
    chk("R5 trig 37", int'(trig_o), 37);
    for (int k = 1; k <= 10; k++) push(pat(k + 500));
    ctrl(3'b001);
    chk_level("R8 clear", 0, 37, 0, 0);
    chk("R8 err cleared", int'(status_o[11]), 0);
    chk("R8 trig kept", int'(trig_o), 37);
    push(16'h1234);
    chk("R8 data after clear", int'(rd_data_o), 16'h1234);
    chk_level("R8 level after clear", 1, 37, 0, 0);

    // R5 zero write ignored
    set_trig(8'd0);
    chk("R5 zero ignored", int'(trig_o), 37);

    // R11 simultaneous push and pop
    push(16'h2222);
    @(negedge clk_i); wr_valid_i = 1'b1; wr_data_i = 16'h3333; rd_en_i = 1'b1;
    @(negedge clk_i); wr_valid_i = 1'b0; rd_en_i = 1'b0;
    chk_level("R11 push+pop", 2, 37, 0, 0);
    chk("R11 head", int'(rd_data_o), 16'h2222);
    pop();
    chk("R11 next", int'(rd_data_o), 16'h3333);

    // R10 enable off: flag set, no irq
    chk("R10 irq off", int'(irq_o), 0);

    // R4/R10 trigger sweep over all fill levels with irq enabled
    foreach (trigs[t]) begin
      ctrl(3'b101);
      set_trig(8'(trigs[t]));
      chk("R5 trig load", int'(trig_o), trigs[t]);
      chk_level("R4 sweep", 0, trigs[t], 1, 0);
      for (int k = 1; k <= DEPTH; k++) begin
        push(pat(k));
        chk_level("R4 sweep", k, trigs[t], 1, 0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule